// File: doc/BRIEF.md
# Two-Bit Burst Address Sequencer

This block turns one supplied start address into the address sequence of a short burst of up to four accesses. On a load cycle it captures the full address, the access type and the ordering mode. On each following advance cycle it steps a two-bit burst count and rebuilds the low two address bits from the captured start bits. The upper bits never change within a burst.

Two orderings are available. The linear order counts upward from the start word and wraps within the aligned four-word group. The interleaved order combines the start word with the count by exclusive-or. During advance cycles the select and write-enable inputs are ignored, so the stored access type carries through the whole burst. If no access has been loaded since reset, or the last load was a deselect, advance cycles have no effect.

The block sits in front of a synchronous memory array. It supplies the address and a stored write flag for every access of a burst. Byte-lane selects are not stored here, so the bus master must present them again on every burst cycle.

Top module: `burst_addr_seq`

## Requirements
- R1: After reset, `op_valid` is 0, `op_write` is 0 and `addr_out` is all zeros.
- R2: When `ld_n` is 0 and `chip_sel` is 1 at a clock edge, the next cycle shows `addr_out` equal to the sampled `addr_in`, `op_valid` at 1, and `op_write` equal to the sampled `wr_en`.
- R3: When `ld_n` is 0 and `chip_sel` is 0 at a clock edge, the next cycle shows `op_valid` at 0 and `op_write` at 0, and `addr_out` keeps its previous value.
- R4: When `ld_n` is 1, `chip_sel` and `wr_en` have no effect, and `op_write` keeps the value captured at the last load.
- R5: During advance cycles, `addr_out` bits above bit 1 stay equal to the loaded address.
- R6: With `lin_order` sampled at 1 at load, the low two bits after k advances equal (start + k) mod 4.
- R7: With `lin_order` sampled at 0 at load, the low two bits after k advances equal start XOR (k mod 4).
- R8: After the fourth access, further advances keep wrapping within the same four-word group (k is taken mod 4).
- R9: An advance while `op_valid` is 0 leaves `addr_out`, `op_valid` and `op_write` unchanged.
- R10: The ordering is fixed when the load happens; a change of `lin_order` during a burst has no effect until the next load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| ld_n | input | 1 | 0 = load a new access, 1 = advance the burst |
| chip_sel | input | 1 | Combined select, sampled only on load cycles |
| wr_en | input | 1 | 1 = write access, sampled only on load cycles |
| lin_order | input | 1 | 1 = linear order, 0 = interleaved order, sampled on load |
| addr_in | input | ADDR_W | External start address |
| addr_out | output | ADDR_W | Address of the current access |
| op_valid | output | 1 | A selected access is stored |
| op_write | output | 1 | The stored access is a write |

## Verification
The bench builds the block with ADDR_W = 6, which leaves four upper bits. Every start word, both orderings and both access types are swept with two different upper-bit patterns. Each burst runs six advances, so wrap-around past the fourth access is covered, and the select and write-enable inputs are toggled during the advances. With this narrow width, every expected address is computed directly from the start word and the advance count. The sweep also includes advances after reset, a deselecting load, and a mode flip in mid-burst.

// File: rtl/bas_pkg.sv
// Package: shared types and constants for the burst address sequencer.
// Assumes bursts are always four words, so the burst count is two bits wide.
package bas_pkg;
    localparam int BURST_W = 2;

    typedef enum logic {
        ORD_XOR    = 1'b0,
        ORD_LINEAR = 1'b1
    } order_e;
endpackage

// File: rtl/bas_ctrl.sv
// Module: burst control state. It stores the valid flag, the access type, the
// ordering and the burst count. Assumes ld_n selects between load and advance;
// select and write enable matter only on load cycles.
module bas_ctrl
    import bas_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               ld_n,
    input  logic               chip_sel,
    input  logic               wr_en,
    input  logic               lin_order,
    output logic [BURST_W-1:0] cnt_q,
    output order_e             ord_q,
    output logic               valid_q,
    output logic               wr_q,
    output logic               take_addr
);
    // Purpose: a selected load captures the external address.
    assign take_addr = !ld_n && chip_sel;

    // Purpose: load, deselect or advance the stored burst state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q   <= '0;
            ord_q   <= ORD_XOR;
            valid_q <= 1'b0;
            wr_q    <= 1'b0;
        end else if (!ld_n) begin
            if (chip_sel) begin
                cnt_q   <= '0;
                ord_q   <= lin_order ? ORD_LINEAR : ORD_XOR;
                valid_q <= 1'b1;
                wr_q    <= wr_en;
            end else begin
                valid_q <= 1'b0;
                wr_q    <= 1'b0;
            end
        end else if (valid_q) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/bas_addr_reg.sv
// Module: start-address register. It holds the address captured on the last
// selected load. Assumes a deselect leaves the stored address unchanged.
module bas_addr_reg #(
    parameter int ADDR_W = 20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              take_addr,
    input  logic [ADDR_W-1:0] addr_in,
    output logic [ADDR_W-1:0] base_q
);
    // Purpose: capture the start address on a selected load.
    always_ff @(posedge clk) begin
        if (!rst_n)         base_q <= '0;
        else if (take_addr) base_q <= addr_in;
    end
endmodule

// File: rtl/bas_order_map.sv
// Module: maps the start word and the burst count to the current low address
// bits. It is purely combinational. Assumes the count wraps at the burst length.
module bas_order_map
    import bas_pkg::*;
(
    input  logic [BURST_W-1:0] start_lo,
    input  logic [BURST_W-1:0] cnt,
    input  order_e             ord,
    output logic [BURST_W-1:0] addr_lo
);
    // Purpose: select the wrapping sum or the exclusive-or ordering.
    always_comb begin
        if (ord == ORD_LINEAR) addr_lo = start_lo + cnt;
        else                   addr_lo = start_lo ^ cnt;
    end
endmodule

// File: rtl/burst_addr_seq.sv
// Module: top of the burst address sequencer. It combines the control state,
// the start-address register and the order map into the current address.
// Assumes ADDR_W is greater than the burst count width.
module burst_addr_seq
    import bas_pkg::*;
#(
    parameter int ADDR_W = 20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ld_n,
    input  logic              chip_sel,
    input  logic              wr_en,
    input  logic              lin_order,
    input  logic [ADDR_W-1:0] addr_in,
    output logic [ADDR_W-1:0] addr_out,
    output logic              op_valid,
    output logic              op_write
);
    localparam int LOW_W = BURST_W;

    logic [LOW_W-1:0]  cnt_q;
    logic [LOW_W-1:0]  addr_lo;
    logic [ADDR_W-1:0] base_q;
    order_e            ord_q;
    logic              take_addr;
    logic              lin_q;

    bas_ctrl u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .ld_n      (ld_n),
        .chip_sel  (chip_sel),
        .wr_en     (wr_en),
        .lin_order (lin_order),
        .cnt_q     (cnt_q),
        .ord_q     (ord_q),
        .valid_q   (op_valid),
        .wr_q      (op_write),
        .take_addr (take_addr)
    );

    bas_addr_reg #(.ADDR_W(ADDR_W)) u_base (
        .clk       (clk),
        .rst_n     (rst_n),
        .take_addr (take_addr),
        .addr_in   (addr_in),
        .base_q    (base_q)
    );

    bas_order_map u_map (
        .start_lo (base_q[LOW_W-1:0]),
        .cnt      (cnt_q),
        .ord      (ord_q),
        .addr_lo  (addr_lo)
    );

    // Purpose: expose the stored ordering as a flag for the checker.
    assign lin_q = (ord_q == ORD_LINEAR);

    // Purpose: upper bits come from the loaded address, low bits from the map.
    assign addr_out = {base_q[ADDR_W-1:LOW_W], addr_lo};
endmodule

// File: rtl/burst_addr_seq_chk.sv
// Module: property checker for burst_addr_seq, attached by bind.
// Assumes it sees the ports and the stored ordering flag.
module burst_addr_seq_chk #(
    parameter int ADDR_W = 20
) (
    input logic              clk,
    input logic              rst_n,
    input logic              ld_n,
    input logic              chip_sel,
    input logic              wr_en,
    input logic [ADDR_W-1:0] addr_in,
    input logic [ADDR_W-1:0] addr_out,
    input logic              op_valid,
    input logic              op_write,
    input logic              lin_q
);
    // R2
    load_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ld_n && chip_sel) |=> (op_valid && addr_out == $past(addr_in) && op_write == $past(wr_en)));

    // R3
    deselect_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ld_n && !chip_sel) |=> (!op_valid && !op_write && $stable(addr_out)));

    // R4
    write_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_n && op_valid) |=> (op_valid && op_write == $past(op_write)));

    // R5
    upper_fixed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ld_n |=> (addr_out[ADDR_W-1:2] == $past(addr_out[ADDR_W-1:2])));

    // R6
    linear_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_n && op_valid && lin_q) |=> (addr_out[1:0] == $past(addr_out[1:0]) + 2'd1));

    // R7
    xor_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_n && op_valid && !lin_q) |=>
            (((addr_out[1:0] ^ $past(addr_out[1:0])) == 2'b01) ||
             ((addr_out[1:0] ^ $past(addr_out[1:0])) == 2'b11)));

    // R9
    idle_advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_n && !op_valid) |=> (!op_valid && !op_write && $stable(addr_out)));
endmodule

bind burst_addr_seq burst_addr_seq_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .ld_n     (ld_n),
    .chip_sel (chip_sel),
    .wr_en    (wr_en),
    .addr_in  (addr_in),
    .addr_out (addr_out),
    .op_valid (op_valid),
    .op_write (op_write),
    .lin_q    (lin_q)
);

// File: tb/tb_burst_addr_seq.sv
`timescale 1ns/1ps
module tb_burst_addr_seq;
    localparam int AW = 6;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          ld_n = 1'b1;
    logic          chip_sel = 1'b0;
    logic          wr_en = 1'b0;
    logic          lin_order = 1'b0;
    logic [AW-1:0] addr_in = '0;
    logic [AW-1:0] addr_out;
    logic          op_valid;
    logic          op_write;

    int n_chk = 0;
    int n_fail = 0;

    always #5 clk = ~clk;

    burst_addr_seq #(.ADDR_W(AW)) dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .ld_n      (ld_n),
        .chip_sel  (chip_sel),
        .wr_en     (wr_en),
        .lin_order (lin_order),
        .addr_in   (addr_in),
        .addr_out  (addr_out),
        .op_valid  (op_valid),
        .op_write  (op_write)
    );

    // Drive inputs at a falling edge, let one rising edge pass, then sample
    // at the next falling edge.
    task automatic cyc(input logic l, input logic cs, input logic we,
                       input logic lo, input logic [AW-1:0] a);
        ld_n = l; chip_sel = cs; wr_en = we; lin_order = lo; addr_in = a;
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk(input string req, input logic [AW-1:0] ea,
                       input logic ev, input logic ew);
        n_chk++;
        if (addr_out !== ea || op_valid !== ev || op_write !== ew) begin
            n_fail++;
            $display("FAIL %s: addr=%0h valid=%0b write=%0b expected addr=%0h valid=%0b write=%0b",
                     req, addr_out, op_valid, op_write, ea, ev, ew);
        end
    endtask

    initial begin
        #(200000 * 10);
        n_fail++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic [AW-1:0] exp_a;
        @(negedge clk);
        cyc(1'b1, 1'b0, 1'b0, 1'b0, '0);
        cyc(1'b1, 1'b0, 1'b0, 1'b0, '0);
        rst_n = 1'b1;
        chk("R1", '0, 1'b0, 1'b0);

        // R9: advances with nothing loaded change nothing
        for (int i = 0; i < 3; i++) begin
            cyc(1'b1, 1'b1, 1'b1, 1'b1, 6'h2d);
            chk("R9", '0, 1'b0, 1'b0);
        end

        // Sweep: both orders, every start word, two upper patterns, both types
        for (int m = 0; m < 2; m++)
            for (int s = 0; s < 4; s++)
                for (int h = 0; h < 2; h++)
                    for (int w = 0; w < 2; w++) begin
                        logic [3:0] hi;
                        hi = (h == 0) ? 4'h0 : 4'hb;
                        exp_a = {hi, s[1:0]};
                        cyc(1'b0, 1'b1, w[0], m[0], exp_a);
                        chk("R2", exp_a, 1'b1, w[0]);
                        for (int k = 1; k <= 6; k++) begin
                            logic [1:0] lo;
                            logic [1:0] kk;
                            kk = k[1:0];
                            lo = (m == 1) ? 2'((s + k) % 4) : (s[1:0] ^ kk);
                            // R4: select and write enable toggled while advancing
                            cyc(1'b1, k[0], ~w[0], m[0], ~exp_a);
                            if (k > 3)      chk("R8", {hi, lo}, 1'b1, w[0]);
                            else if (m == 1) chk("R6 R5 R4", {hi, lo}, 1'b1, w[0]);
                            else            chk("R7 R5 R4", {hi, lo}, 1'b1, w[0]);
                        end
                    end

        // R10: mode flipped mid-burst stays linear until the next load
        cyc(1'b0, 1'b1, 1'b0, 1'b1, 6'h26);
        chk("R10", 6'h26, 1'b1, 1'b0);
        for (int k = 1; k <= 3; k++) begin
            cyc(1'b1, 1'b1, 1'b0, 1'b0, '0);
            chk("R10", {4'h9, 2'((2 + k) % 4)}, 1'b1, 1'b0);
        end
        exp_a = {4'h9, 2'b01};

        // R3: a deselecting load clears the flags and holds the address
        cyc(1'b0, 1'b0, 1'b1, 1'b0, 6'h3f);
        chk("R3", exp_a, 1'b0, 1'b0);
        cyc(1'b1, 1'b1, 1'b1, 1'b1, 6'h11);
        chk("R9", exp_a, 1'b0, 1'b0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule